// File: doc/BRIEF.md
# Oscillator Power-Down and Wake Controller

This block decides when the reference oscillator may be switched off and when it must come back. Software sets a power-down bit, and a clock-mode bit selects when that request takes hold. With the mode bit at 1 the oscillator stops at once. With the mode bit at 0 the stop waits until the clock generator reports that it is idle.

Five event lines can bring the oscillator back: the non-maskable interrupt and interrupts 0 to 3. Each line passes through a two-flop synchroniser and a rising-edge detector. A rising edge on a line whose wake-enable bit is 0 clears the power-down bit, while that bit is set. The same edge restarts a startup counter, and a stable flag stays low until that counter has run a full startup interval.

Software loads the control bits through simple write strobes. An idle-status input stands in for the idle logic of the clock generator.

Top module: `osc_pd_ctrl`

## Requirements
- R1: Reset state:
  - the power-down bit is 0 and the oscillator-off output is 0;
  - the clock-mode bit is the parameter `MODE_RST` (default 0);
  - all five wake-enable bits are 1;
  - the stable flag is 1.

  Reset is asserted asynchronously. Its release passes through two flops, so the block starts working on the third clock edge after `rst_ni` rises.
- R2: A write strobe for the power-down bit, the clock-mode bit or the wake-enable field loads the new value at the next clock edge. Without a strobe, the register holds its value.
- R3: When the clock-mode bit is 1, the oscillator-off output rises at the same edge at which the power-down bit becomes 1.
- R4: When the clock-mode bit is 0, a set power-down bit leaves the oscillator-off output low until `clk_idle_i` is sampled high. The output rises at that edge. It then stays high until the power-down bit clears, even after `clk_idle_i` falls.
- R5: The oscillator-off output falls at the same edge at which the power-down bit clears. It is never 1 while the power-down bit is 0.
- R6: Wake lines map to bits as follows: bit 0 is the non-maskable interrupt, bits 1 to 4 are interrupts 0 to 3. A wake-enable bit of 0 enables its line. Suppose `wake_i[k]` rises before edge E0, bit k of the enable field is 0, and the power-down bit is set. Then the power-down bit is 0 after edge E2, the third edge that samples the high level.
- R7: A rising edge on a line whose enable bit is 1 leaves the power-down bit set.
- R8: A rising edge while the power-down bit is 0 has no effect: the stable flag and the counter are not disturbed.
- R9: Only transitions wake the oscillator. A wake line held high does not clear a power-down bit that is set later.
- R10: A wake event resets the startup counter to zero. The stable flag is then 0 for exactly `STABLE_CYCLES` clock edges (default 41032) and returns to 1 at the edge that completes the count.
- R11: While `cnt_en_i` is 0, the stable flag reads 1 in the same cycle, whatever the count.
- R12: If a wake event and a write of 1 to the power-down bit arrive at the same edge, the wake wins and the bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_we_i | input | 1 | Write strobe for the power-down bit |
| pd_i | input | 1 | Value written to the power-down bit |
| mode_we_i | input | 1 | Write strobe for the clock-mode bit |
| mode_i | input | 1 | Value written to the clock-mode bit (1 = immediate) |
| wken_we_i | input | 1 | Write strobe for the wake-enable field |
| wken_i | input | 5 | Value written to the wake-enable field (0 = enabled) |
| cnt_en_i | input | 1 | Startup counter enable; 0 forces the stable flag to 1 |
| clk_idle_i | input | 1 | Clock generator idle status |
| wake_i | input | 5 | Asynchronous wake event lines |
| pd_o | output | 1 | Power-down bit |
| osc_off_o | output | 1 | Oscillator power-down command |
| mode_o | output | 1 | Clock-mode bit |
| wken_o | output | 5 | Wake-enable field |
| stable_o | output | 1 | Oscillator stable flag |

## Verification
The results are due at different times:
- Register writes and the oscillator-off output are due one edge after the stimulus.
- A wake line's effect on the power-down bit, and the drop of the stable flag, are due at the third edge that sees the line high.
- The stable flag's return is due exactly `STABLE_CYCLES` edges after that.
- The counter-disable override shows in the same cycle.

A reference model in the bench keeps a history of the sampled wake lines and the startup count as an integer. It compares every output half a period after each edge. Directed checks count exactly these edge numbers before they sample, including the boundary cycle one edge before the count completes.

// File: rtl/osc_pd_pkg.sv
package osc_pd_pkg;
  // Number of wake event lines: bit 0 = NMI, bits 1..4 = interrupts 0..3
  localparam int unsigned WAKE_N = 5;
  // Default startup interval in reference clock cycles
  localparam int unsigned STARTUP_CYCLES = 41032;
  typedef logic [WAKE_N-1:0] wake_vec_t;
endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/osc_wake_edge.sv
module osc_wake_edge #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] wake_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g]   <= 1'b0;
        s2_q[g]   <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        s1_q[g]   <= wake_i[g];
        s2_q[g]   <= s1_q[g];
        prev_q[g] <= s2_q[g];
      end
    end
    assign rise_o[g] = s2_q[g] & ~prev_q[g];
  end
endmodule

// File: rtl/osc_stable_cnt.sv
module osc_stable_cnt #(
  parameter int unsigned LIMIT = 41032
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic en_i,
  output logic stable_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done;

  assign done = (cnt_q == CNT_END);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)  cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_END;
    else         cnt_q <= cnt_d;
  end

  assign stable_o = done | ~en_i;
endmodule

// File: rtl/osc_pd_ctrl.sv
module osc_pd_ctrl
  import osc_pd_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = STARTUP_CYCLES,
  parameter logic        MODE_RST      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_we_i,
  input  logic              pd_i,
  input  logic              mode_we_i,
  input  logic              mode_i,
  input  logic              wken_we_i,
  input  logic [WAKE_N-1:0] wken_i,
  input  logic              cnt_en_i,
  input  logic              clk_idle_i,
  input  logic [WAKE_N-1:0] wake_i,
  output logic              pd_o,
  output logic              osc_off_o,
  output logic              mode_o,
  output logic [WAKE_N-1:0] wken_o,
  output logic              stable_o
);
  logic      rst_int_n;
  wake_vec_t rise;
  logic      wake_hit;
  logic      pd_q, pd_d, off_q, off_d, mode_q, mode_d;
  wake_vec_t wken_q, wken_d;

  osc_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_int_n)
  );

  osc_wake_edge #(.N(WAKE_N)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .wake_i(wake_i),
    .rise_o(rise)
  );

  // Enable bits are active low; wake only counts while power-down is pending
  assign wake_hit = pd_q & (|(rise & ~wken_q));

  osc_stable_cnt #(.LIMIT(STABLE_CYCLES)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .restart_i(wake_hit),
    .en_i     (cnt_en_i),
    .stable_o (stable_o)
  );

  always_comb begin
    pd_d   = pd_q;
    mode_d = mode_q;
    wken_d = wken_q;
    if (wake_hit)     pd_d = 1'b0;
    else if (pd_we_i) pd_d = pd_i;
    if (mode_we_i)    mode_d = mode_i;
    if (wken_we_i)    wken_d = wken_i;
    // Off latches once the request is honoured: immediate mode or idle seen
    off_d = pd_d & (off_q | mode_d | clk_idle_i);
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pd_q   <= 1'b0;
      off_q  <= 1'b0;
      mode_q <= MODE_RST;
      wken_q <= '1;
    end else begin
      pd_q   <= pd_d;
      off_q  <= off_d;
      mode_q <= mode_d;
      wken_q <= wken_d;
    end
  end

  assign pd_o      = pd_q;
  assign osc_off_o = off_q;
  assign mode_o    = mode_q;
  assign wken_o    = wken_q;
endmodule

// File: rtl/osc_pd_ctrl_chk.sv
module osc_pd_ctrl_chk
  import osc_pd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pd_we_i,
  input logic              wken_we_i,
  input logic              cnt_en_i,
  input logic              clk_idle_i,
  input logic              pd_o,
  input logic              osc_off_o,
  input logic              mode_o,
  input logic [WAKE_N-1:0] wken_o,
  input logic              stable_o
);
  p_wken_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wken_we_i |=> $stable(wken_o));

  p_immediate_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o && pd_o) |-> osc_off_o);

  p_deferred_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && !osc_off_o && !clk_idle_i) |=> (!osc_off_o || mode_o));

  p_off_needs_pd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_off_o |-> pd_o);

  p_disabled_keeps_pd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_o && wken_o == '1 && !pd_we_i) |=> pd_o);

  p_wake_restarts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pd_o) && !$past(pd_we_i) && cnt_en_i) |-> !stable_o);

  p_cnt_off_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |-> stable_o);
endmodule

bind osc_pd_ctrl osc_pd_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pd_we_i   (pd_we_i),
  .wken_we_i (wken_we_i),
  .cnt_en_i  (cnt_en_i),
  .clk_idle_i(clk_idle_i),
  .pd_o      (pd_o),
  .osc_off_o (osc_off_o),
  .mode_o    (mode_o),
  .wken_o    (wken_o),
  .stable_o  (stable_o)
);

// File: tb/osc_pd_ctrl_bench.sv
module osc_pd_ctrl_bench;
  localparam int LIMIT = 41032;

  logic       clk, rst_ni;
  logic       pd_we, pd_d, mode_we, mode_d, wken_we, cnt_en, idle;
  logic [4:0] wken_d, wake;
  logic       pd_o, off_o, mode_o, stable_o;
  logic [4:0] wken_o;

  int vectors = 0;
  int fails   = 0;

  osc_pd_ctrl u_osc_pd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .pd_we_i(pd_we), .pd_i(pd_d),
    .mode_we_i(mode_we), .mode_i(mode_d),
    .wken_we_i(wken_we), .wken_i(wken_d),
    .cnt_en_i(cnt_en), .clk_idle_i(idle), .wake_i(wake),
    .pd_o(pd_o), .osc_off_o(off_o), .mode_o(mode_o),
    .wken_o(wken_o), .stable_o(stable_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // ---------------- reference model ----------------
  bit         m_pd, m_off, m_mode;
  bit [4:0]   m_wken;
  int         m_cnt;
  int         m_rel;
  bit [4:0]   hist [$];

  task automatic model_reset();
    m_pd = 0; m_off = 0; m_mode = 0; m_wken = 5'h1F; m_cnt = LIMIT;
    hist = '{5'd0, 5'd0, 5'd0, 5'd0};
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rel = 0;
      model_reset();
    end else if (m_rel < 2) begin
      m_rel++;
      model_reset();
    end else begin
      bit [4:0] rise;
      bit       hit;
      hist.push_front(wake);
      void'(hist.pop_back());
      rise = hist[2] & ~hist[3];
      hit  = m_pd && ((rise & ~m_wken) != 0);
      if (hit)          m_pd = 0;
      else if (pd_we)   m_pd = pd_d;
      if (mode_we)      m_mode = mode_d;
      if (wken_we)      m_wken = wken_d;
      m_off = m_pd && (m_off || m_mode || idle);
      if (hit)               m_cnt = 0;
      else if (m_cnt < LIMIT) m_cnt++;
    end
  end

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      cmp("R6 pd bit",      pd_o,   m_pd);
      cmp("R4 osc off",     off_o,  m_off);
      cmp("R2 mode",        mode_o, m_mode);
      cmp("R2 wake enable", wken_o, m_wken);
      cmp("R10 stable",     stable_o, (m_cnt == LIMIT) || !cnt_en);
    end
  end

  // ---------------- stimulus ----------------
  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_pd(bit v);
    pd_we = 1; pd_d = v; edges(1); pd_we = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_ni = 0; pd_we = 0; pd_d = 0; mode_we = 0; mode_d = 0;
    wken_we = 0; wken_d = 0; cnt_en = 1; idle = 0; wake = 0;
    edges(3);
    rst_ni = 1;
    edges(4);
    // R1 reset values
    cmp("R1 pd",     pd_o, 0);
    cmp("R1 off",    off_o, 0);
    cmp("R1 mode",   mode_o, 0);
    cmp("R1 wken",   wken_o, 5'h1F);
    cmp("R1 stable", stable_o, 1);

    // R2 writes land on next edge
    mode_we = 1; mode_d = 1; wken_we = 1; wken_d = 5'b11110;
    edges(1);
    mode_we = 0; wken_we = 0;
    cmp("R2 mode write", mode_o, 1);
    cmp("R2 wken write", wken_o, 5'b11110);

    // R3 immediate power-down
    wr_pd(1);
    cmp("R3 pd set", pd_o, 1);
    cmp("R3 off same edge", off_o, 1);

    // R7 disabled line (interrupt 0, bit 1)
    wake[1] = 1;
    edges(6);
    cmp("R7 pd kept", pd_o, 1);

    // R6/R5/R10 enabled NMI line
    wake[0] = 1;
    edges(2);
    cmp("R6 pd before third edge", pd_o, 1);
    edges(1);
    cmp("R6 pd cleared", pd_o, 0);
    cmp("R5 off cleared", off_o, 0);
    cmp("R10 stable low", stable_o, 0);
    edges(LIMIT - 1);
    cmp("R10 stable low one before end", stable_o, 0);
    edges(1);
    cmp("R10 stable back", stable_o, 1);

    // R8 edge while pd clear
    wake[0] = 0; edges(3);
    wake[0] = 1; edges(5);
    cmp("R8 pd stays clear", pd_o, 0);
    cmp("R8 stable undisturbed", stable_o, 1);

    // R9 held-high line does not retrigger
    wr_pd(1);
    edges(6);
    cmp("R9 pd kept", pd_o, 1);

    // R11 counter disable override
    wake[0] = 0; edges(3);
    wake[0] = 1; edges(3);
    cmp("R11 pd cleared", pd_o, 0);
    cmp("R11 stable low", stable_o, 0);
    cnt_en = 0; #0.5;
    cmp("R11 stable forced", stable_o, 1);
    cnt_en = 1; #0.5;
    cmp("R11 stable low again", stable_o, 0);

    // R4 deferred power-down, interrupt 3 (bit 4)
    mode_we = 1; mode_d = 0; wken_we = 1; wken_d = 5'b01111;
    edges(1);
    mode_we = 0; wken_we = 0;
    wr_pd(1);
    edges(4);
    cmp("R4 off waits", off_o, 0);
    idle = 1; edges(1); idle = 0;
    cmp("R4 off on idle", off_o, 1);
    edges(3);
    cmp("R4 off held", off_o, 1);
    wake[4] = 1; edges(3);
    cmp("R6 bit4 clears pd", pd_o, 0);
    cmp("R5 off follows", off_o, 0);

    // R12 wake beats a simultaneous write of 1
    wr_pd(1);
    wake[4] = 0; edges(3);
    wake[4] = 1; edges(2);
    pd_we = 1; pd_d = 1;
    edges(1);
    pd_we = 0;
    cmp("R12 wake wins", pd_o, 0);
    edges(4);
    finish_run();
  end
endmodule